// File: doc/BRIEF.md
# Idleness-Driven Voltage/Frequency Mode Sequencer

This block selects one of six voltage/frequency operating points for an application core. It does this by comparing the core's measured idle percentage against a programmable target. A period timer counts a slow tick and raises one evaluation per regulation period. At each evaluation the block compares the two percentages and decides on a move of at most one operating point. A busier core moves toward performance; an idler core moves toward power saving.

A move is carried out as an ordered pair of requests to an external supply regulator and an external clock generator. Each request is held until its acknowledge arrives. A move toward performance changes the supply first and the clock second. A move toward power saving changes the clock first and the supply second. The current operating point index, the voltage and frequency codes, and a body-bias enable are presented continuously, so the surrounding logic can drive the regulator and clock generator directly.

Top module: `dvfs_idle_seq`

## Requirements
- R1: After reset the block is at index 0, with voltage code 1100 and frequency code 800. Body bias is enabled, busy is low, and neither request is asserted.
- R2: The operating points by index 0..5 are (mV, MHz): (1100,800), (1000,640), (900,490), (860,420), (835,370), (800,300). Index 0 is the fastest. Body bias is enabled at every index.
- R3: At an evaluation, idleness below the target steps the index down by one, toward performance. Idleness above the target steps it up by one, toward power saving.
- R4: The index changes by at most one per evaluation and stays within 0..5. A request to go beyond index 0 or index 5 makes no change and no request, and only pulses done.
- R5: When stepping toward performance, voltage_req rises first with the new voltage code while the frequency code keeps its old value. Only after voltage_ack does freq_req rise with the new frequency code.
- R6: When stepping toward power saving, freq_req rises first with the new frequency code while the voltage code is unchanged. Only after freq_ack does voltage_req rise with the new voltage code.
- R7: done pulses for one cycle in the cycle after the final acknowledge, and the index takes its new value in that same cycle. When idleness equals the target, done pulses in the cycle after the evaluation and no request is raised.
- R8: Idleness and target are 7-bit unsigned percentages. Any value above 100 is treated as 100 before the comparison.
- R9: Evaluations occur every P slow ticks. P is the period configuration value clamped to the range 100..5000, and a configuration of 0 selects 5000.
- R10: busy is high while any request is outstanding. Each request stays asserted with stable codes until acknowledged, and evaluations that fall during a busy interval are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse of the slow time base |
| period_cfg | input | 13 | Regulation period in slow ticks (0 selects the default) |
| idle_pct | input | 7 | Measured idleness percentage |
| target_pct | input | 7 | Target idleness percentage |
| voltage_ack | input | 1 | Regulator reports the supply change as done |
| freq_ack | input | 1 | Clock generator reports the frequency change as done |
| voltage_req | output | 1 | Supply change request, held until acknowledged |
| freq_req | output | 1 | Clock change request, held until acknowledged |
| voltage_code | output | 11 | Supply set point in mV |
| freq_code | output | 10 | Clock set point in MHz |
| bias_en | output | 1 | Body-bias enable of the current point |
| mode_idx | output | 3 | Current operating point index |
| busy | output | 1 | A change sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of an evaluation |

## Verification
The embedded properties check several things on every cycle. Requests stay asserted with frozen codes until acknowledged. On a move toward performance, the clock request is only ever preceded by an acknowledged supply request, and the opposite holds on a move toward power saving. The index never jumps by more than one and never leaves its range. Done and busy never overlap.

Other behaviour only the directed scenarios can show. These include the numeric codes at each of the six points and the saturation at both ends. They also include the clamping of out-of-range percentages, the exact spacing of evaluations for several period settings, and that an evaluation falling inside a long handshake leaves no trace.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UP_V,
      ST_UP_F,
      ST_DN_F,
      ST_DN_V
   } seq_state_t;

   function automatic int opp_mv(input int idx);
      case (idx)
         0:       return 1100;
         1:       return 1000;
         2:       return 900;
         3:       return 860;
         4:       return 835;
         default: return 800;
      endcase
   endfunction

   function automatic int opp_mhz(input int idx);
      case (idx)
         0:       return 800;
         1:       return 640;
         2:       return 490;
         3:       return 420;
         4:       return 370;
         default: return 300;
      endcase
   endfunction

endpackage

// File: rtl/dvfs_opp_table.sv
module dvfs_opp_table #(
   parameter int NUM_MODES = 6,
   parameter int MW        = 3,
   parameter int VW        = 11,
   parameter int FW        = 10,
   parameter logic [NUM_MODES-1:0] BIAS_MASK = '1
) (
   input  logic [MW-1:0] sel,
   output logic [VW-1:0] mv,
   output logic [FW-1:0] mhz,
   output logic          bias
);
   import dvfs_seq_pkg::*;

   localparam int SLOTS = 2 ** MW;

   logic [VW-1:0] mv_tab   [SLOTS];
   logic [FW-1:0] mhz_tab  [SLOTS];
   logic          bias_tab [SLOTS];

   // slots past the last point mirror the last point
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam int SRC = (i < NUM_MODES) ? i : NUM_MODES - 1;
      assign mv_tab[i]   = VW'(opp_mv(SRC));
      assign mhz_tab[i]  = FW'(opp_mhz(SRC));
      assign bias_tab[i] = BIAS_MASK[SRC];
   end

   assign mv   = mv_tab[sel];
   assign mhz  = mhz_tab[sel];
   assign bias = bias_tab[sel];

endmodule

// File: rtl/dvfs_period_timer.sv
module dvfs_period_timer #(
   parameter int PW         = 13,
   parameter int MIN_TICKS  = 100,
   parameter int MAX_TICKS  = 5000,
   parameter int DEF_TICKS  = 5000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [PW-1:0] period_cfg,
   output logic          expire
);
   if (MIN_TICKS < 1 || MIN_TICKS > MAX_TICKS || MAX_TICKS >= 2 ** PW
       || DEF_TICKS < MIN_TICKS || DEF_TICKS > MAX_TICKS) begin : g_bad_period
      $error("period limits do not fit the counter");
   end

   logic [PW-1:0] cnt;
   logic [PW-1:0] eff;

   always_comb begin
      if (period_cfg == '0)                 eff = PW'(DEF_TICKS);
      else if (period_cfg < PW'(MIN_TICKS)) eff = PW'(MIN_TICKS);
      else if (period_cfg > PW'(MAX_TICKS)) eff = PW'(MAX_TICKS);
      else                                  eff = period_cfg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (tick) begin
            if (cnt >= eff - 1'b1) begin
               cnt    <= '0;
               expire <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R9: an evaluation is only raised by a slow tick
   assert_expire_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expire) |-> $past(tick));

endmodule

// File: rtl/dvfs_step_decide.sv
module dvfs_step_decide #(
   parameter int IW        = 7,
   parameter int MW        = 3,
   parameter int NUM_MODES = 6,
   parameter int PCT_MAX   = 100
) (
   input  logic [IW-1:0] idle_pct,
   input  logic [IW-1:0] target_pct,
   input  logic [MW-1:0] cur_mode,
   output logic          want_up,
   output logic          want_dn,
   output logic [MW-1:0] nxt_mode
);
   if (PCT_MAX >= 2 ** IW) begin : g_bad_pct
      $error("percentage ceiling exceeds input width");
   end

   logic [IW-1:0] idle_c, tgt_c;

   assign idle_c = (idle_pct   > IW'(PCT_MAX)) ? IW'(PCT_MAX) : idle_pct;
   assign tgt_c  = (target_pct > IW'(PCT_MAX)) ? IW'(PCT_MAX) : target_pct;

   // up = toward performance = lower index
   assign want_up = (idle_c < tgt_c) && (cur_mode != '0);
   assign want_dn = (idle_c > tgt_c) && (cur_mode != MW'(NUM_MODES - 1));

   always_comb begin
      if (want_up)      nxt_mode = cur_mode - 1'b1;
      else if (want_dn) nxt_mode = cur_mode + 1'b1;
      else              nxt_mode = cur_mode;
   end

endmodule

// File: rtl/dvfs_idle_seq.sv
module dvfs_idle_seq #(
   parameter int NUM_MODES = 6,
   parameter int MW        = $clog2(NUM_MODES),
   parameter int VW        = 11,
   parameter int FW        = 10,
   parameter int IW        = 7,
   parameter int PW        = 13,
   parameter int MIN_TICKS = 100,
   parameter int MAX_TICKS = 5000,
   parameter int DEF_TICKS = 5000,
   parameter logic [NUM_MODES-1:0] BIAS_MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic [PW-1:0] period_cfg,
   input  logic [IW-1:0] idle_pct,
   input  logic [IW-1:0] target_pct,
   input  logic          voltage_ack,
   input  logic          freq_ack,
   output logic          voltage_req,
   output logic          freq_req,
   output logic [VW-1:0] voltage_code,
   output logic [FW-1:0] freq_code,
   output logic          bias_en,
   output logic [MW-1:0] mode_idx,
   output logic          busy,
   output logic          done
);
   import dvfs_seq_pkg::*;

   if (NUM_MODES < 2 || NUM_MODES > 6 || VW < 11 || FW < 10) begin : g_bad_cfg
      $error("mode count or code widths out of range");
   end

   seq_state_t    state;
   logic          expire;
   logic          want_up, want_dn;
   logic [MW-1:0] nxt_mode, tgt_mode;
   logic [VW-1:0] tab_mv, pend_mv;
   logic [FW-1:0] tab_mhz, pend_mhz;
   logic          tab_bias, pend_bias;

   dvfs_period_timer #(
      .PW(PW), .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS), .DEF_TICKS(DEF_TICKS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick),
      .period_cfg(period_cfg), .expire(expire)
   );

   dvfs_step_decide #(
      .IW(IW), .MW(MW), .NUM_MODES(NUM_MODES)
   ) u_decide (
      .idle_pct(idle_pct), .target_pct(target_pct), .cur_mode(mode_idx),
      .want_up(want_up), .want_dn(want_dn), .nxt_mode(nxt_mode)
   );

   dvfs_opp_table #(
      .NUM_MODES(NUM_MODES), .MW(MW), .VW(VW), .FW(FW), .BIAS_MASK(BIAS_MASK)
   ) u_table (
      .sel(nxt_mode), .mv(tab_mv), .mhz(tab_mhz), .bias(tab_bias)
   );

   assign voltage_req = (state == ST_UP_V) || (state == ST_DN_V);
   assign freq_req    = (state == ST_UP_F) || (state == ST_DN_F);
   assign busy        = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         mode_idx     <= '0;
         tgt_mode     <= '0;
         voltage_code <= VW'(opp_mv(0));
         freq_code    <= FW'(opp_mhz(0));
         bias_en      <= BIAS_MASK[0];
         pend_mv      <= '0;
         pend_mhz     <= '0;
         pend_bias    <= 1'b0;
         done         <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (expire) begin
                  tgt_mode  <= nxt_mode;
                  pend_mv   <= tab_mv;
                  pend_mhz  <= tab_mhz;
                  pend_bias <= tab_bias;
                  if (want_up) begin
                     state        <= ST_UP_V;
                     voltage_code <= tab_mv;
                  end else if (want_dn) begin
                     state     <= ST_DN_F;
                     freq_code <= tab_mhz;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            ST_UP_V: if (voltage_ack) begin
               state     <= ST_UP_F;
               freq_code <= pend_mhz;
            end
            ST_DN_F: if (freq_ack) begin
               state        <= ST_DN_V;
               voltage_code <= pend_mv;
            end
            ST_UP_F, ST_DN_V: if ((state == ST_UP_F) ? freq_ack : voltage_ack) begin
               state    <= ST_IDLE;
               mode_idx <= tgt_mode;
               bias_en  <= pend_bias;
               done     <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: requests persist with frozen codes until acknowledged
   assert_volt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (voltage_req && !voltage_ack) |=> (voltage_req && $stable(voltage_code) && $stable(freq_code)));
   assert_freq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_req && !freq_ack) |=> (freq_req && $stable(voltage_code) && $stable(freq_code)));

   // R5: on a performance step the clock request follows an acknowledged supply request
   assert_up_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(freq_req) && (tgt_mode < mode_idx)) |-> $past(voltage_req && voltage_ack));

   // R6: on a saving step the supply request follows an acknowledged clock request
   assert_dn_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(voltage_req) && (tgt_mode > mode_idx)) |-> $past(freq_req && freq_ack));

   // R4: single-step moves within range, only at completion
   assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_idx != $past(mode_idx)) |->
         (done && (({1'b0, mode_idx} + 1'b1 == {1'b0, $past(mode_idx)})
                || ({1'b0, $past(mode_idx)} + 1'b1 == {1'b0, mode_idx}))));
   assert_mode_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_idx < MW'(NUM_MODES));

   // R7: completion is never reported while a sequence runs
   assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/dvfs_idle_seq_test.sv
module dvfs_idle_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b1;
   logic [12:0] period_cfg = 13'd100;
   logic [6:0]  idle_pct = 7'd40;
   logic [6:0]  target_pct = 7'd40;
   logic        voltage_ack = 1'b0;
   logic        freq_ack = 1'b0;
   logic        voltage_req, freq_req, bias_en, busy, done;
   logic [10:0] voltage_code;
   logic [9:0]  freq_code;
   logic [2:0]  mode_idx;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   dvfs_idle_seq uut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .period_cfg(period_cfg),
      .idle_pct(idle_pct), .target_pct(target_pct),
      .voltage_ack(voltage_ack), .freq_ack(freq_ack),
      .voltage_req(voltage_req), .freq_req(freq_req),
      .voltage_code(voltage_code), .freq_code(freq_code),
      .bias_en(bias_en), .mode_idx(mode_idx), .busy(busy), .done(done)
   );

   function automatic int exp_mv(input int m);
      int t [6] = '{1100, 1000, 900, 860, 835, 800};
      return t[m];
   endfunction

   function automatic int exp_mhz(input int m);
      int t [6] = '{800, 640, 490, 420, 370, 300};
      return t[m];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // kind: 0 done, 1 voltage_req, 2 freq_req, -1 nothing
   task automatic wait_event(output int kind);
      kind = -1;
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         if (done)        begin kind = 0; return; end
         if (voltage_req) begin kind = 1; return; end
         if (freq_req)    begin kind = 2; return; end
      end
   endtask

   task automatic pulse_v();
      voltage_ack = 1'b1;
      @(negedge clk);
      voltage_ack = 1'b0;
   endtask

   task automatic pulse_f();
      freq_ack = 1'b1;
      @(negedge clk);
      freq_ack = 1'b0;
   endtask

   task automatic check_point(input int m, input string req);
      chk(mode_idx == 3'(m), req, mode_idx, m);
      chk(voltage_code == 11'(exp_mv(m)), req, voltage_code, exp_mv(m));
      chk(freq_code == 10'(exp_mhz(m)), req, freq_code, exp_mhz(m));
      chk(bias_en == 1'b1, req, bias_en, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_point(0, "R1");
      chk(!busy && !voltage_req && !freq_req && !done, "R1",
          {busy, voltage_req, freq_req, done}, 0);
   endtask

   task automatic t_step_down(input int m);
      int kind;
      wait_event(kind);
      chk(kind == 2, "R6 clock first", kind, 2);
      chk(freq_code == 10'(exp_mhz(m + 1)), "R6", freq_code, exp_mhz(m + 1));
      chk(voltage_code == 11'(exp_mv(m)), "R6", voltage_code, exp_mv(m));
      chk(busy == 1'b1, "R10", busy, 1);
      pulse_f();
      chk(voltage_req && !freq_req, "R6", {voltage_req, freq_req}, 2);
      chk(voltage_code == 11'(exp_mv(m + 1)), "R6", voltage_code, exp_mv(m + 1));
      chk(mode_idx == 3'(m), "R7", mode_idx, m);
      pulse_v();
      chk(done && !busy, "R7", {done, busy}, 2);
      check_point(m + 1, "R2 R3");
   endtask

   task automatic t_step_up(input int m);
      int kind;
      wait_event(kind);
      chk(kind == 1, "R5 supply first", kind, 1);
      chk(voltage_code == 11'(exp_mv(m - 1)), "R5", voltage_code, exp_mv(m - 1));
      chk(freq_code == 10'(exp_mhz(m)), "R5", freq_code, exp_mhz(m));
      pulse_v();
      chk(freq_req && !voltage_req, "R5", {voltage_req, freq_req}, 1);
      chk(freq_code == 10'(exp_mhz(m - 1)), "R5", freq_code, exp_mhz(m - 1));
      pulse_f();
      chk(done && !busy, "R7", {done, busy}, 2);
      check_point(m - 1, "R2 R3");
   endtask

   task automatic t_saturate(input int m, input string req);
      int kind;
      wait_event(kind);
      chk(kind == 0, req, kind, 0);
      chk(mode_idx == 3'(m), req, mode_idx, m);
   endtask

   task automatic t_equal();
      int kind;
      idle_pct = 7'd55; target_pct = 7'd55;
      wait_event(kind);
      chk(kind == 0, "R7 equal", kind, 0);
      chk(mode_idx == 3'd0, "R7 equal", mode_idx, 0);
   endtask

   task automatic t_clamp();
      int kind;
      idle_pct = 7'd120; target_pct = 7'd100;   // both read as 100
      wait_event(kind);
      chk(kind == 0, "R8 equal after clamp", kind, 0);
      idle_pct = 7'd100; target_pct = 7'd127;
      wait_event(kind);
      chk(kind == 0, "R8 target clamp", kind, 0);
      idle_pct = 7'd127; target_pct = 7'd99;    // 100 > 99
      t_step_down(0);
   endtask

   task automatic t_ignore();
      int kind;
      idle_pct = 7'd90; target_pct = 7'd20;
      wait_event(kind);
      chk(kind == 2, "R10", kind, 2);
      idle_pct = 7'd20;                          // no further moves after this one
      repeat (250) @(negedge clk);
      chk(freq_req && busy && !voltage_req, "R10 held", {freq_req, busy, voltage_req}, 6);
      chk(freq_code == 10'(exp_mhz(2)), "R10 stable", freq_code, exp_mhz(2));
      chk(mode_idx == 3'd1, "R10", mode_idx, 1);
      pulse_f();
      repeat (250) @(negedge clk);
      chk(voltage_req && voltage_code == 11'(exp_mv(2)), "R10 held", voltage_code, exp_mv(2));
      pulse_v();
      chk(done, "R7", done, 1);
      repeat (300) @(negedge clk);
      check_point(2, "R4 R10");
   endtask

   task automatic measure_gap(input logic [12:0] cfg, input int expv, input string req);
      int n;
      int kind;
      idle_pct = 7'd30; target_pct = 7'd30;
      period_cfg = cfg;
      wait_event(kind);
      wait_event(kind);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!done && n < 6000);
      chk(n == expv, req, n, expv);
   endtask

   initial begin
      #(4 * 190000);
      if (!ended) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      idle_pct = 7'd5; target_pct = 7'd60;       // wants more performance at index 0
      t_saturate(0, "R4 top end");
      t_equal();
      t_clamp();                                 // ends at index 1
      idle_pct = 7'd95; target_pct = 7'd10;
      for (int m = 1; m < 5; m++) t_step_down(m);
      t_saturate(5, "R4 bottom end");
      idle_pct = 7'd3; target_pct = 7'd80;
      for (int m = 5; m > 1; m--) t_step_up(m);  // ends at index 1
      t_ignore();
      measure_gap(13'd7, 100, "R9 low clamp");
      measure_gap(13'd150, 150, "R9 in range");
      measure_gap(13'd0, 5000, "R9 default");
      measure_gap(13'd6000, 5000, "R9 high clamp");
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule